// File: doc/BRIEF.md
# Two-stage restricted-ratio clock divider

This block derives a slow clock from a fast input clock in two stages. A prescaler divides by one of six fixed ratios chosen by a 3-bit code. An output stage then divides the prescaler result again by a ratio taken from a 7-bit field. The field holds the ratio minus one. Only a ratio of 1 or an even ratio up to 128 is allowed, and an odd request above 1 is raised to the next even value. The total output period is the product of the two ratios, counted in input clock cycles.

New settings are captured on a one-cycle load strobe. They are applied only when the output clock starts its next period, so a period already running always finishes with its old ratios and no runt pulse is produced. The output always has a 50 % duty cycle. When the output stage divides by 1 and the prescaler ratio is odd, a flop clocked on the falling edge adds the missing half cycle of high time. An unused prescaler code does not change the prescaler ratio. It raises the illegal-code flag instead, and the output-stage field from the same load is still accepted.

A small control state machine sequences the updates. Its states are ST_START, ST_RUN and ST_ARMED:
- ST_START is the single cycle after reset. It forces the counters to restart. It moves to ST_RUN, or to ST_ARMED if a load arrives in that cycle.
- ST_RUN moves to ST_ARMED on a load.
- ST_ARMED copies the pending ratios into the active ones at the end of an output period. It then returns to ST_RUN, or stays in ST_ARMED if a further load arrives in that same cycle.

Top module: `rr_clkdiv`

## Requirements
- R1: Prescaler code 3'b000 divides by 4, 3'b001 by 5, 3'b010 by 6, 3'b011 by 7, 3'b101 by 9 and 3'b111 by 11.
- R2: A load with prescaler code 3'b100 or 3'b110 leaves the prescaler ratio at its last valid value, while the output-stage field of that load is still taken.
- R3: `illegal_code` is 1 from the cycle after a load with an unused prescaler code, and 0 from the cycle after a load with a used code. It does not change between loads and is 0 after reset.
- R4: The output-stage ratio is the field value plus one: field 0 divides by 1 and field 127 divides by 128.
- R5: An odd output-stage ratio above 1 is rounded up to the next even ratio; for example, field 2 gives ratio 4.
- R6: The output period is prescaler ratio times output-stage ratio, in input cycles. Ratios loaded during a period take effect only from the next rising edge of `clk_out`.
- R7: `clk_out` is high for exactly half of each period, including the case of an odd prescaler ratio with output-stage ratio 1, where the high time includes a half input cycle.
- R8: During reset `clk_out` is low. After reset the ratios are prescaler 4 and output stage 1, and the first period starts at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | One-cycle strobe that captures `hs_code` and `n1_field` |
| hs_code | input | 3 | Prescaler ratio code |
| n1_field | input | N1_W | Output-stage ratio minus one |
| clk_out | output | 1 | Divided clock |
| illegal_code | output | 1 | Last load carried an unused prescaler code |

## Verification
Each used prescaler code is tried with output-stage ratio 1. This separates the six ratios by period length, and for the odd ones it shows whether the half-cycle extension gives exact 50 % duty. Even output-stage ratios are then combined with an odd prescaler ratio, and an odd field is loaded to show rounding. The extreme fields 0 and 127 mark the two ends of the range. The two unused codes are loaded after a known valid ratio, which shows that the old ratio is kept while the new output-stage field still applies. Every load lands inside a running period, and that period is measured too, so an early switch shows up as a wrong length.

// File: rtl/rr_clkdiv_pkg.sv
package rr_clkdiv_pkg;

    localparam int HS_CODE_W = 3;
    localparam int HS_RAT_W  = 4;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic                ok;
        logic [HS_RAT_W-1:0] ratio;
    } hs_dec_t;

    // Sparse prescaler ratio set; two codes carry no ratio.
    function automatic hs_dec_t hs_decode(input logic [HS_CODE_W-1:0] code);
        hs_dec_t d;
        d.ok = 1'b1;
        case (code)
            3'b000:  d.ratio = 4'd4;
            3'b001:  d.ratio = 4'd5;
            3'b010:  d.ratio = 4'd6;
            3'b011:  d.ratio = 4'd7;
            3'b101:  d.ratio = 4'd9;
            3'b111:  d.ratio = 4'd11;
            default: begin
                d.ok    = 1'b0;
                d.ratio = 4'd0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rr_clkdiv_ctrl.sv
module rr_clkdiv_ctrl
    import rr_clkdiv_pkg::*;
#(
    parameter int                  N1_W         = 7,
    parameter int                  N_RAT_W      = N1_W + 1,
    parameter logic [HS_CODE_W-1:0] RST_HS_CODE = 3'b000,
    parameter logic [N1_W-1:0]     RST_N1_FIELD = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [HS_CODE_W-1:0] hs_code,
    input  logic [N1_W-1:0]      n1_field,
    input  logic                 bnd,
    output logic                 restart,
    output logic [HS_RAT_W-1:0]  cur_hs,
    output logic [HS_RAT_W-1:0]  nxt_hs,
    output logic [N_RAT_W-1:0]   cur_n,
    output logic [N_RAT_W-1:0]   nxt_n,
    output logic                 illegal_code
);

    // Field holds ratio minus one; odd ratios above one move up to even.
    function automatic logic [N_RAT_W-1:0] n1_ratio(input logic [N1_W-1:0] f);
        logic [N_RAT_W-1:0] r;
        r = N_RAT_W'(f) + N_RAT_W'(1);
        if (r != N_RAT_W'(1) && r[0])
            r = r + N_RAT_W'(1);
        return r;
    endfunction

    localparam hs_dec_t            RST_HS_DEC = hs_decode(RST_HS_CODE);
    localparam logic [N_RAT_W-1:0] RST_N_RAT  = n1_ratio(RST_N1_FIELD);

    ctl_state_e          state, state_nx;
    hs_dec_t             dec;
    logic [HS_RAT_W-1:0] pend_hs;
    logic [N_RAT_W-1:0]  pend_n;
    logic                apply;

    assign dec     = hs_decode(hs_code);
    assign apply   = (state == ST_ARMED) && bnd;
    assign restart = (state == ST_START) || bnd;
    assign nxt_hs  = apply ? pend_hs : cur_hs;
    assign nxt_n   = apply ? pend_n  : cur_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_START;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_START: state_nx = load ? ST_ARMED : ST_RUN;
            ST_RUN:   state_nx = load ? ST_ARMED : ST_RUN;
            ST_ARMED: state_nx = (bnd && !load) ? ST_RUN : ST_ARMED;
            default:  state_nx = ST_START;
        endcase
    end

    // Ratio and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_hs      <= RST_HS_DEC.ratio;
            pend_n       <= RST_N_RAT;
            cur_hs       <= RST_HS_DEC.ratio;
            cur_n        <= RST_N_RAT;
            illegal_code <= 1'b0;
        end else begin
            if (apply) begin
                cur_hs <= pend_hs;
                cur_n  <= pend_n;
            end
            if (load) begin
                if (dec.ok) pend_hs <= dec.ratio;
                pend_n       <= n1_ratio(n1_field);
                illegal_code <= !dec.ok;
            end
        end
    end

endmodule

// File: rtl/rr_clkdiv_pre.sv
module rr_clkdiv_pre
    import rr_clkdiv_pkg::*;
#(
    parameter bit ASSIST = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [HS_RAT_W-1:0] cur_hs,
    input  logic [HS_RAT_W-1:0] nxt_hs,
    output logic [HS_RAT_W-1:0] p_cnt,
    output logic                p_end,
    output logic                pre_clk
);

    logic [HS_RAT_W-1:0] rat;
    logic [HS_RAT_W-1:0] p_nx;
    logic                pos_hi;
    logic                odd_q;
    logic                neg_q;

    assign p_end = (p_cnt == cur_hs - HS_RAT_W'(1));
    assign rat   = restart ? nxt_hs : cur_hs;
    assign p_nx  = (restart || p_end) ? '0 : p_cnt + HS_RAT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_cnt  <= '0;
            pos_hi <= 1'b0;
            odd_q  <= 1'b0;
        end else begin
            p_cnt  <= p_nx;
            pos_hi <= (p_nx < (rat >> 1));
            odd_q  <= rat[0];
        end
    end

    generate
        if (ASSIST) begin : g_assist
            // Half-cycle extension of the high phase for odd ratios.
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) neg_q <= 1'b0;
                else        neg_q <= pos_hi;
            end
        end else begin : g_plain
            assign neg_q = 1'b0;
        end
    endgenerate

    assign pre_clk = pos_hi | (odd_q & neg_q);

endmodule

// File: rtl/rr_clkdiv_post.sv
module rr_clkdiv_post #(
    parameter int N_RAT_W = 8,
    parameter int CNT_W   = N_RAT_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               p_end,
    input  logic               pre_clk,
    input  logic [N_RAT_W-1:0] cur_n,
    input  logic [N_RAT_W-1:0] nxt_n,
    output logic               bnd,
    output logic               clk_out
);

    logic [CNT_W-1:0]   n_cnt;
    logic [CNT_W-1:0]   n_nx;
    logic [N_RAT_W-1:0] ratn;
    logic               n_end;
    logic               n_hi;
    logic               byp_q;

    assign n_end = ({1'b0, n_cnt} == cur_n - N_RAT_W'(1));
    assign bnd   = p_end && n_end;
    assign ratn  = restart ? nxt_n : cur_n;

    always_comb begin
        if (restart)    n_nx = '0;
        else if (p_end) n_nx = n_end ? '0 : n_cnt + CNT_W'(1);
        else            n_nx = n_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_cnt <= '0;
            n_hi  <= 1'b0;
            byp_q <= 1'b1;
        end else begin
            n_cnt <= n_nx;
            n_hi  <= ({1'b0, n_nx} < (ratn >> 1));
            byp_q <= (ratn == N_RAT_W'(1));
        end
    end

    assign clk_out = byp_q ? pre_clk : n_hi;

endmodule

// File: rtl/rr_clkdiv.sv
module rr_clkdiv
    import rr_clkdiv_pkg::*;
#(
    parameter int                   N1_W         = 7,
    parameter bit                   ASSIST       = 1'b1,
    parameter logic [HS_CODE_W-1:0] RST_HS_CODE  = 3'b000,
    parameter logic [N1_W-1:0]      RST_N1_FIELD = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [HS_CODE_W-1:0] hs_code,
    input  logic [N1_W-1:0]      n1_field,
    output logic                 clk_out,
    output logic                 illegal_code
);

    localparam int N_RAT_W = N1_W + 1;

    logic                restart;
    logic                bnd;
    logic                p_end;
    logic                pre_clk;
    logic [HS_RAT_W-1:0] cur_hs;
    logic [HS_RAT_W-1:0] nxt_hs;
    logic [HS_RAT_W-1:0] p_cnt;
    logic [N_RAT_W-1:0]  cur_n;
    logic [N_RAT_W-1:0]  nxt_n;

    rr_clkdiv_ctrl #(
        .N1_W        (N1_W),
        .N_RAT_W     (N_RAT_W),
        .RST_HS_CODE (RST_HS_CODE),
        .RST_N1_FIELD(RST_N1_FIELD)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .hs_code     (hs_code),
        .n1_field    (n1_field),
        .bnd         (bnd),
        .restart     (restart),
        .cur_hs      (cur_hs),
        .nxt_hs      (nxt_hs),
        .cur_n       (cur_n),
        .nxt_n       (nxt_n),
        .illegal_code(illegal_code)
    );

    rr_clkdiv_pre #(
        .ASSIST(ASSIST)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .cur_hs (cur_hs),
        .nxt_hs (nxt_hs),
        .p_cnt  (p_cnt),
        .p_end  (p_end),
        .pre_clk(pre_clk)
    );

    rr_clkdiv_post #(
        .N_RAT_W(N_RAT_W)
    ) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .p_end  (p_end),
        .pre_clk(pre_clk),
        .cur_n  (cur_n),
        .nxt_n  (nxt_n),
        .bnd    (bnd),
        .clk_out(clk_out)
    );

endmodule

// File: rtl/rr_clkdiv_chk.sv
module rr_clkdiv_chk #(
    parameter int N_RAT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load,
    input logic [2:0]         hs_code,
    input logic               illegal_code,
    input logic [3:0]         cur_hs,
    input logic [N_RAT_W-1:0] cur_n,
    input logic [3:0]         p_cnt,
    input logic               bnd
);

    assert_illegal_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load && (hs_code == 3'b100 || hs_code == 3'b110) |=> illegal_code);

    assert_illegal_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load && !(hs_code == 3'b100 || hs_code == 3'b110) |=> !illegal_code);

    assert_illegal_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(illegal_code));

    assert_hs_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cur_hs inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd11});

    assert_n_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_n == N_RAT_W'(1)) || !cur_n[0]);

    assert_apply_at_bnd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_hs) || !$stable(cur_n)) |-> $past(bnd));

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        p_cnt < cur_hs);

endmodule

bind rr_clkdiv rr_clkdiv_chk #(.N_RAT_W(N_RAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .hs_code     (hs_code),
    .illegal_code(illegal_code),
    .cur_hs      (cur_hs),
    .cur_n       (cur_n),
    .p_cnt       (p_cnt),
    .bnd         (bnd)
);

// File: tb/rr_clkdiv_tb.sv
module rr_clkdiv_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [2:0] hs_code = 3'b000;
    logic [6:0] n1_field = 7'd0;
    logic       clk_out;
    logic       illegal_code;

    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string tag_q[$];

    always #(HALF) clk = ~clk;

    rr_clkdiv u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .hs_code     (hs_code),
        .n1_field    (n1_field),
        .clk_out     (clk_out),
        .illegal_code(illegal_code)
    );

    // Monitor: measures each full period in half input cycles (R7).
    initial begin : mon
        bit prev;
        bit started;
        int hi;
        int lo;
        int e;
        string t;
        prev = 1'b0; started = 1'b0; hi = 0; lo = 0;
        forever begin
            @(posedge clk or negedge clk);
            #2;
            if (clk_out && !prev) begin
                if (started && exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (hi != e || lo != e) begin
                        errors++;
                        $display("FAIL %s: high %0d low %0d half-cycles, expected %0d each", t, hi, lo, e);
                    end
                end
                hi = 1; lo = 0; started = 1'b1;
            end else if (clk_out) begin
                hi++;
            end else begin
                lo++;
            end
            prev = clk_out;
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wait_rise();
        bit a;
        bit b;
        forever begin
            @(negedge clk); #2 a = clk_out;
            @(posedge clk); #2 b = clk_out;
            if (!a && b) break;
        end
    endtask

    // Driver: load inside a running period, queue old then new periods (R6).
    task automatic run_case(input logic [2:0] c, input logic [6:0] f, input int old_t,
                            input int new_t, input int nper, input logic ill, input string tag);
        wait_rise();
        #1;
        exp_q.push_back(old_t);
        tag_q.push_back({tag, " running period keeps old ratio R6"});
        @(negedge clk);
        hs_code = c; n1_field = f; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check_bit({tag, " illegal flag R3"}, illegal_code, ill);
        for (int i = 0; i < nper; i++) begin
            exp_q.push_back(new_t);
            tag_q.push_back(tag);
        end
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired, run did not complete");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_bit("R8 clk_out low in reset", clk_out, 1'b0);
        check_bit("R8 flag clear in reset", illegal_code, 1'b0);
        rst_n = 1'b1;
        // First old period is the reset default 4 x 1 (R8).
        run_case(3'b000, 7'd1,   4,    8,    2, 1'b0, "R8 R1 R4 code0 field1");
        run_case(3'b001, 7'd0,   8,    5,    2, 1'b0, "R1 R7 ratio5");
        run_case(3'b011, 7'd0,   5,    7,    2, 1'b0, "R1 R7 ratio7");
        run_case(3'b101, 7'd0,   7,    9,    2, 1'b0, "R1 R7 ratio9");
        run_case(3'b111, 7'd0,   9,    11,   2, 1'b0, "R1 R7 ratio11");
        run_case(3'b011, 7'd1,   11,   14,   2, 1'b0, "R1 R6 ratio7 times2");
        run_case(3'b010, 7'd2,   14,   24,   2, 1'b0, "R5 field2 rounds to 4");
        run_case(3'b100, 7'd5,   24,   36,   2, 1'b1, "R2 R3 code4 keeps 6");
        run_case(3'b110, 7'd0,   36,   6,    2, 1'b1, "R2 R3 code6 keeps 6");
        run_case(3'b111, 7'd127, 6,    1408, 1, 1'b0, "R4 field127");
        run_case(3'b001, 7'd9,   1408, 50,   2, 1'b0, "R3 R6 field9");
        run_case(3'b000, 7'd0,   50,   4,    2, 1'b0, "R4 field0");
        summary();
        $finish;
    end

endmodule